// File: doc/BRIEF.md
# Temperature Limit Monitor with Passive Fan Cutoff

This block watches two signed temperature readings, one from the die itself (local) and one from an external sensing diode (remote). Each reading is an 11-bit two's complement number with a resolution of 0.125 °C. The block compares each reading against four programmable thresholds: an upper bound, a lower bound, a thermal-shutdown threshold and a critical threshold. It reports one registered flag per comparison.

Each threshold is stored as a single byte. The byte holds the top eight bits of an 11-bit threshold, and the three fractional bits are taken as zero. A ninth register holds a 6-bit passive-cooling threshold that ranges from 0 °C to +63 °C in whole degrees. When the chosen active temperature is at or below that threshold, the block raises a force-zero signal. The downstream fan duty controller uses this signal to drive the fan at 0 % duty.

All nine registers share one byte-wide port. The port has a write strobe and a combinational read path, both addressed by the same address bus.

Top module: `temp_limit_mon`

## Requirements
- R1: After reset, the registers read back as follows: 0x14=0x3C, 0x15=0x00, 0x16=0x46, 0x18=0x50, 0x19=0x00, 0x1A=0x64, 0x1B=0x50, 0x1D=0x69, and the passive register 0x1C=0x00.
- R2: The address map is: local upper 0x14, local lower 0x15, local shutdown 0x16, remote upper 0x18, remote lower 0x19, remote shutdown 0x1A, local critical 0x1B, passive 0x1C, remote critical 0x1D. A write with `cfg_wr_en` high stores `cfg_wr_data` at the addressed register, and `cfg_rd_data` returns the register at `cfg_addr` in the same cycle. A write to any other address changes no register, and a read of any other address returns 0x00.
- R3: Only bits 5:0 of a write to the passive register are stored. Bits 7:6 are ignored and always read as zero.
- R4: A threshold byte B stands for the signed 11-bit value {B, 3'b000}. `*_high` is 1 exactly when the signed temperature sampled one clock earlier is strictly greater than the upper threshold.
- R5: `*_low` is 1 exactly when the signed temperature sampled one clock earlier is strictly less than the lower threshold.
- R6: `*_therm` is 1 exactly when the signed temperature sampled one clock earlier is strictly greater than the shutdown threshold.
- R7: `*_crit` is 1 exactly when the signed temperature sampled one clock earlier is strictly greater than the critical threshold.
- R8: The active temperature is `local_temp` when `fan_src_remote` is 0 and `remote_temp` when it is 1. One clock later, `fan_force_zero` is 1 exactly when that active temperature, read as signed, is less than or equal to {2'b00, P[5:0], 3'b000}.
- R9: While `rst` is high at a clock edge, all eight flags and `fan_force_zero` are cleared to 0.
- R10: All comparisons are signed, so a negative temperature (bit 10 set) compares below any non-negative threshold. Thresholds with bit 7 set stand for negative temperatures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address for both read and write |
| cfg_wr_data | input | 8 | Register write data |
| cfg_rd_data | output | 8 | Read data of the register at `cfg_addr` |
| local_temp | input | 11 | Local temperature, signed, 0.125 °C per LSB |
| remote_temp | input | 11 | Remote temperature, signed, 0.125 °C per LSB |
| fan_src_remote | input | 1 | Selects the temperature for the passive comparison (1 = remote) |
| local_high | output | 1 | Local reading above its upper bound |
| local_low | output | 1 | Local reading below its lower bound |
| local_therm | output | 1 | Local reading above its shutdown threshold |
| local_crit | output | 1 | Local reading above its critical threshold |
| remote_high | output | 1 | Remote reading above its upper bound |
| remote_low | output | 1 | Remote reading below its lower bound |
| remote_therm | output | 1 | Remote reading above its shutdown threshold |
| remote_crit | output | 1 | Remote reading above its critical threshold |
| fan_force_zero | output | 1 | Fan duty must be forced to 0 % |

## Verification
The hardest cases to reach are the exact-equality edges: a reading equal to a threshold must not trip the strict flags, but it must trip the passive cutoff. Negative thresholds must also be checked against readings that straddle the sign boundary. The stimulus reaches these cases by sweeping every one of the 2048 codes on both channels at once, with the remote channel running in mirrored order. The sweep runs under three threshold sets, one of which is full of negative and extreme bytes. The passive source select toggles during the sweep, so both channels pass every passive threshold in each direction.

// File: rtl/tlm_pkg.sv
package tlm_pkg;

    localparam int TEMP_W = 11;
    localparam int LIM_W  = 8;
    localparam int FRAC_W = TEMP_W - LIM_W;
    localparam int PSV_W  = 6;
    localparam int ADDR_W = 8;
    localparam int NUM_LIM = 8;
    localparam int NUM_CH  = 2;

    localparam logic [ADDR_W-1:0] PSV_ADDR = 8'h1C;

    typedef enum logic [2:0] {
        LIM_LHI = 3'd0,
        LIM_LLO = 3'd1,
        LIM_LTH = 3'd2,
        LIM_RHI = 3'd3,
        LIM_RLO = 3'd4,
        LIM_RTH = 3'd5,
        LIM_LCR = 3'd6,
        LIM_RCR = 3'd7
    } lim_sel_e;

    typedef struct packed {
        logic hi;
        logic lo;
        logic therm;
        logic crit;
    } chan_flags_t;

    typedef struct packed {
        logic [LIM_W-1:0] hi;
        logic [LIM_W-1:0] lo;
        logic [LIM_W-1:0] therm;
        logic [LIM_W-1:0] crit;
    } chan_limits_t;

    function automatic logic [ADDR_W-1:0] lim_addr(input int idx);
        case (idx)
            0:       return 8'h14;
            1:       return 8'h15;
            2:       return 8'h16;
            3:       return 8'h18;
            4:       return 8'h19;
            5:       return 8'h1A;
            6:       return 8'h1B;
            default: return 8'h1D;
        endcase
    endfunction

    function automatic logic [LIM_W-1:0] lim_reset(input int idx);
        case (idx)
            0:       return 8'h3C;
            1:       return 8'h00;
            2:       return 8'h46;
            3:       return 8'h50;
            4:       return 8'h00;
            5:       return 8'h64;
            6:       return 8'h50;
            default: return 8'h69;
        endcase
    endfunction

endpackage

// File: rtl/tlm_regfile.sv
module tlm_regfile
    import tlm_pkg::*;
#(
    parameter int N_LIM = NUM_LIM,
    parameter int P_W   = PSV_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [LIM_W-1:0]             wr_data,
    output logic [LIM_W-1:0]             rd_data,
    output logic [N_LIM-1:0][LIM_W-1:0]  lim_q,
    output logic [P_W-1:0]               psv_q
);

    localparam int PAD_W = LIM_W - P_W;

    for (genvar g = 0; g < N_LIM; g++) begin : g_lim
        always_ff @(posedge clk) begin
            if (rst) begin
                lim_q[g] <= lim_reset(g);
            end else if (wr_en && (addr == lim_addr(g))) begin
                lim_q[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            psv_q <= '0;
        end else if (wr_en && (addr == PSV_ADDR)) begin
            psv_q <= wr_data[P_W-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_LIM; i++) begin
            if (addr == lim_addr(i)) begin
                rd_data = lim_q[i];
            end
        end
        if (addr == PSV_ADDR) begin
            rd_data = {{PAD_W{1'b0}}, psv_q};
        end
    end

endmodule

// File: rtl/tlm_chan_cmp.sv
module tlm_chan_cmp
    import tlm_pkg::*;
#(
    parameter int T_W = TEMP_W,
    parameter int L_W = LIM_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [T_W-1:0] temp,
    input  chan_limits_t   lims,
    output chan_flags_t    flags_q
);

    localparam int F_W = T_W - L_W;

    logic signed [T_W-1:0] t_s;
    logic signed [T_W-1:0] hi_s, lo_s, th_s, cr_s;
    chan_flags_t           flags_d;

    always_comb begin
        t_s  = $signed(temp);
        hi_s = $signed({lims.hi,    {F_W{1'b0}}});
        lo_s = $signed({lims.lo,    {F_W{1'b0}}});
        th_s = $signed({lims.therm, {F_W{1'b0}}});
        cr_s = $signed({lims.crit,  {F_W{1'b0}}});
        flags_d.hi    = t_s > hi_s;
        flags_d.lo    = t_s < lo_s;
        flags_d.therm = t_s > th_s;
        flags_d.crit  = t_s > cr_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

endmodule

// File: rtl/tlm_passive.sv
module tlm_passive
    import tlm_pkg::*;
#(
    parameter int T_W = TEMP_W,
    parameter int P_W = PSV_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [T_W-1:0] local_t,
    input  logic [T_W-1:0] remote_t,
    input  logic           use_remote,
    input  logic [P_W-1:0] psv,
    output logic           force_q
);

    localparam int HI_PAD = T_W - P_W - FRAC_W;

    logic signed [T_W-1:0] act_s;
    logic signed [T_W-1:0] thr_s;

    always_comb begin
        act_s = use_remote ? $signed(remote_t) : $signed(local_t);
        thr_s = $signed({{HI_PAD{1'b0}}, psv, {FRAC_W{1'b0}}});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            force_q <= 1'b0;
        end else begin
            force_q <= (act_s <= thr_s);
        end
    end

endmodule

// File: rtl/temp_limit_mon.sv
module temp_limit_mon
    import tlm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LIM_W-1:0]  cfg_wr_data,
    output logic [LIM_W-1:0]  cfg_rd_data,
    input  logic [TEMP_W-1:0] local_temp,
    input  logic [TEMP_W-1:0] remote_temp,
    input  logic              fan_src_remote,
    output logic              local_high,
    output logic              local_low,
    output logic              local_therm,
    output logic              local_crit,
    output logic              remote_high,
    output logic              remote_low,
    output logic              remote_therm,
    output logic              remote_crit,
    output logic              fan_force_zero
);

    logic [NUM_LIM-1:0][LIM_W-1:0] lim_q;
    logic [PSV_W-1:0]              psv_q;
    chan_limits_t                  ch_lims [NUM_CH];
    chan_flags_t                   ch_flags [NUM_CH];
    logic [TEMP_W-1:0]             ch_temp [NUM_CH];

    tlm_regfile #(.N_LIM(NUM_LIM), .P_W(PSV_W)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .addr    (cfg_addr),
        .wr_data (cfg_wr_data),
        .rd_data (cfg_rd_data),
        .lim_q   (lim_q),
        .psv_q   (psv_q)
    );

    always_comb begin
        ch_temp[0]       = local_temp;
        ch_temp[1]       = remote_temp;
        ch_lims[0].hi    = lim_q[LIM_LHI];
        ch_lims[0].lo    = lim_q[LIM_LLO];
        ch_lims[0].therm = lim_q[LIM_LTH];
        ch_lims[0].crit  = lim_q[LIM_LCR];
        ch_lims[1].hi    = lim_q[LIM_RHI];
        ch_lims[1].lo    = lim_q[LIM_RLO];
        ch_lims[1].therm = lim_q[LIM_RTH];
        ch_lims[1].crit  = lim_q[LIM_RCR];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tlm_chan_cmp #(.T_W(TEMP_W), .L_W(LIM_W)) cmp_i (
            .clk     (clk),
            .rst     (rst),
            .temp    (ch_temp[c]),
            .lims    (ch_lims[c]),
            .flags_q (ch_flags[c])
        );
    end

    tlm_passive #(.T_W(TEMP_W), .P_W(PSV_W)) psv_i (
        .clk        (clk),
        .rst        (rst),
        .local_t    (local_temp),
        .remote_t   (remote_temp),
        .use_remote (fan_src_remote),
        .psv        (psv_q),
        .force_q    (fan_force_zero)
    );

    assign local_high   = ch_flags[0].hi;
    assign local_low    = ch_flags[0].lo;
    assign local_therm  = ch_flags[0].therm;
    assign local_crit   = ch_flags[0].crit;
    assign remote_high  = ch_flags[1].hi;
    assign remote_low   = ch_flags[1].lo;
    assign remote_therm = ch_flags[1].therm;
    assign remote_crit  = ch_flags[1].crit;

endmodule

// File: rtl/tlm_checker.sv
module tlm_checker
    import tlm_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          cfg_wr_en,
    input logic [ADDR_W-1:0]             cfg_addr,
    input logic [LIM_W-1:0]              cfg_rd_data,
    input logic [TEMP_W-1:0]             local_temp,
    input logic [TEMP_W-1:0]             remote_temp,
    input logic                          fan_src_remote,
    input logic                          local_high,
    input logic                          local_low,
    input logic                          local_therm,
    input logic                          local_crit,
    input logic                          remote_high,
    input logic                          remote_low,
    input logic                          remote_therm,
    input logic                          remote_crit,
    input logic                          fan_force_zero,
    input logic [NUM_LIM-1:0][LIM_W-1:0] lim_q,
    input logic [PSV_W-1:0]              psv_q
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_FLAGS_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        !past_ok |-> ({local_high, local_low, local_therm, local_crit, remote_high,
                       remote_low, remote_therm, remote_crit, fan_force_zero} == '0))
        else $error("flags not cleared by reset"); // R9

    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(cfg_wr_en)) |-> ($stable(lim_q) && $stable(psv_q)))
        else $error("register changed without write"); // R2

    AST_PSV_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr == PSV_ADDR) |-> (cfg_rd_data[LIM_W-1:PSV_W] == '0))
        else $error("passive upper bits nonzero"); // R3

    AST_LOCAL_HIGH: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (local_high == ($signed($past(local_temp)) >
                     $signed({$past(lim_q[LIM_LHI]), {FRAC_W{1'b0}}}))))
        else $error("local high mismatch"); // R4

    AST_REMOTE_HIGH: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (remote_high == ($signed($past(remote_temp)) >
                     $signed({$past(lim_q[LIM_RHI]), {FRAC_W{1'b0}}}))))
        else $error("remote high mismatch"); // R4

    AST_LOCAL_LOW: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (local_low == ($signed($past(local_temp)) <
                     $signed({$past(lim_q[LIM_LLO]), {FRAC_W{1'b0}}}))))
        else $error("local low mismatch"); // R5

    AST_REMOTE_LOW: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (remote_low == ($signed($past(remote_temp)) <
                     $signed({$past(lim_q[LIM_RLO]), {FRAC_W{1'b0}}}))))
        else $error("remote low mismatch"); // R5

    AST_LOCAL_THERM: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (local_therm == ($signed($past(local_temp)) >
                     $signed({$past(lim_q[LIM_LTH]), {FRAC_W{1'b0}}}))))
        else $error("local therm mismatch"); // R6

    AST_REMOTE_THERM: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (remote_therm == ($signed($past(remote_temp)) >
                     $signed({$past(lim_q[LIM_RTH]), {FRAC_W{1'b0}}}))))
        else $error("remote therm mismatch"); // R6

    AST_LOCAL_CRIT: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (local_crit == ($signed($past(local_temp)) >
                     $signed({$past(lim_q[LIM_LCR]), {FRAC_W{1'b0}}}))))
        else $error("local crit mismatch"); // R7

    AST_REMOTE_CRIT: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (remote_crit == ($signed($past(remote_temp)) >
                     $signed({$past(lim_q[LIM_RCR]), {FRAC_W{1'b0}}}))))
        else $error("remote crit mismatch"); // R7

    AST_PASSIVE_CUTOFF: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (fan_force_zero ==
            ($signed($past(fan_src_remote) ? $past(remote_temp) : $past(local_temp)) <=
             $signed({2'b00, $past(psv_q), {FRAC_W{1'b0}}}))))
        else $error("passive cutoff mismatch"); // R8

    AST_NEG_NOT_HIGH: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(local_temp[TEMP_W-1]) && !$past(lim_q[LIM_LHI][LIM_W-1])) |-> !local_high)
        else $error("negative reading flagged high"); // R10

endmodule

bind temp_limit_mon tlm_checker chk_i (
    .clk            (clk),
    .rst            (rst),
    .cfg_wr_en      (cfg_wr_en),
    .cfg_addr       (cfg_addr),
    .cfg_rd_data    (cfg_rd_data),
    .local_temp     (local_temp),
    .remote_temp    (remote_temp),
    .fan_src_remote (fan_src_remote),
    .local_high     (local_high),
    .local_low      (local_low),
    .local_therm    (local_therm),
    .local_crit     (local_crit),
    .remote_high    (remote_high),
    .remote_low     (remote_low),
    .remote_therm   (remote_therm),
    .remote_crit    (remote_crit),
    .fan_force_zero (fan_force_zero),
    .lim_q          (lim_q),
    .psv_q          (psv_q)
);

// File: tb/temp_limit_mon_tb_top.sv
`timescale 1ns/1ps
module temp_limit_mon_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr_en;
    logic [7:0]  cfg_addr;
    logic [7:0]  cfg_wr_data;
    logic [7:0]  cfg_rd_data;
    logic [10:0] local_temp;
    logic [10:0] remote_temp;
    logic        fan_src_remote;
    logic        local_high, local_low, local_therm, local_crit;
    logic        remote_high, remote_low, remote_therm, remote_crit;
    logic        fan_force_zero;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // order: local hi, lo, therm; remote hi, lo, therm; local crit; remote crit
    logic [7:0] map_addr [8] = '{8'h14, 8'h15, 8'h16, 8'h18, 8'h19, 8'h1A, 8'h1B, 8'h1D};
    logic [7:0] map_rst  [8] = '{8'h3C, 8'h00, 8'h46, 8'h50, 8'h00, 8'h64, 8'h50, 8'h69};
    logic [7:0] cur_lim  [8];
    logic [7:0] cur_psv;

    always #4 clk = ~clk;

    temp_limit_mon dut_i (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .local_temp(local_temp), .remote_temp(remote_temp),
        .fan_src_remote(fan_src_remote),
        .local_high(local_high), .local_low(local_low),
        .local_therm(local_therm), .local_crit(local_crit),
        .remote_high(remote_high), .remote_low(remote_low),
        .remote_therm(remote_therm), .remote_crit(remote_crit),
        .fan_force_zero(fan_force_zero)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int temp_val(input logic [10:0] v);
        return (v >= 11'd1024) ? int'(v) - 2048 : int'(v);
    endfunction

    function automatic int lim_val(input logic [7:0] b);
        return ((b >= 8'd128) ? int'(b) - 256 : int'(b)) * 8;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rd_data;
    endtask

    task automatic load(input logic [7:0] l [8], input logic [7:0] p);
        for (int i = 0; i < 8; i++) begin
            wr(map_addr[i], l[i]);
            cur_lim[i] = l[i];
        end
        wr(8'h1C, p);
        cur_psv = p & 8'h3F;
    endtask

    task automatic sweep(input string tag);
        for (int t = 0; t < 2048; t++) begin
            int lt, rt, act;
            @(negedge clk);
            local_temp     = 11'(t);
            remote_temp    = 11'(2047 - t);
            fan_src_remote = t[1];
            @(negedge clk);
            lt  = temp_val(11'(t));
            rt  = temp_val(11'(2047 - t));
            act = fan_src_remote ? rt : lt;
            chk({"R4 local high ", tag},  int'(local_high),   int'(lt > lim_val(cur_lim[0])));
            chk({"R5 local low ", tag},   int'(local_low),    int'(lt < lim_val(cur_lim[1])));
            chk({"R6 local therm ", tag}, int'(local_therm),  int'(lt > lim_val(cur_lim[2])));
            chk({"R4 remote high ", tag}, int'(remote_high),  int'(rt > lim_val(cur_lim[3])));
            chk({"R5 remote low ", tag},  int'(remote_low),   int'(rt < lim_val(cur_lim[4])));
            chk({"R6 remote therm ", tag},int'(remote_therm), int'(rt > lim_val(cur_lim[5])));
            chk({"R7 local crit ", tag},  int'(local_crit),   int'(lt > lim_val(cur_lim[6])));
            chk({"R7 remote crit ", tag}, int'(remote_crit),  int'(rt > lim_val(cur_lim[7])));
            chk({"R8 passive ", tag},     int'(fan_force_zero), int'(act <= int'(cur_psv) * 8));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog actual=timeout expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] set_b [8] = '{8'h05, 8'hF6, 8'h10, 8'h80, 8'h7F, 8'hFF, 8'h7F, 8'h00};
        logic [7:0] set_c [8] = '{8'h19, 8'h0A, 8'h1E, 8'hEC, 8'hE2, 8'h02, 8'h28, 8'h7E};
        rst = 1'b1; cfg_wr_en = 1'b0; cfg_addr = 8'h00; cfg_wr_data = 8'h00;
        local_temp = 11'h400; remote_temp = 11'h3FF; fan_src_remote = 1'b0;
        repeat (3) @(negedge clk);
        // R9: outputs cleared while reset is held
        chk("R9 reset flags", int'({local_high, local_low, local_therm, local_crit,
            remote_high, remote_low, remote_therm, remote_crit, fan_force_zero}), 0);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) begin
            rd(map_addr[i], d);
            chk("R1 reset value", int'(d), int'(map_rst[i]));
            cur_lim[i] = map_rst[i];
        end
        rd(8'h1C, d);
        chk("R1 passive reset", int'(d), 0);
        cur_psv = 8'h00;

        // R2: write each register with a distinct value and read it back
        for (int i = 0; i < 8; i++) wr(map_addr[i], 8'hA0 + 8'(i));
        for (int i = 0; i < 8; i++) begin
            rd(map_addr[i], d);
            chk("R2 readback", int'(d), int'(8'hA0 + 8'(i)));
        end
        // R2: unmapped address ignored and reads zero
        wr(8'h17, 8'h5A);
        rd(8'h17, d);
        chk("R2 unmapped read", int'(d), 0);
        for (int i = 0; i < 8; i++) begin
            rd(map_addr[i], d);
            chk("R2 unmapped no effect", int'(d), int'(8'hA0 + 8'(i)));
        end
        rd(8'h1C, d);
        chk("R2 unmapped psv intact", int'(d), 0);
        // R3: upper passive bits dropped
        wr(8'h1C, 8'hFF);
        rd(8'h1C, d);
        chk("R3 passive upper bits", int'(d), 8'h3F);
        wr(8'h1C, 8'hC5);
        rd(8'h1C, d);
        chk("R3 passive keeps low bits", int'(d), 8'h05);

        // reset-value thresholds, all codes (R10 sign handling included)
        load(map_rst, 8'h00);
        sweep("R10 defaults");
        // negative and extreme thresholds, passive wider than 6 bits
        load(set_b, 8'hFF);
        sweep("R10 extremes");
        load(set_c, 8'h55);
        sweep("R10 mixed");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule